// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block sits on the host side of a serially programmed RF step attenuator. A client hands it an attenuation request as a quarter-dB code (the setting in dB multiplied by four) with a one-cycle valid strobe. The block frames the code into an eight-bit word and shifts it out, least significant bit first, on a data pin and a clock pin. It then pulses a latch-enable pin, which makes the attenuator apply the shifted word.

All pin timing is derived from the system clock. Each minimum time is given in nanoseconds and turned into a whole number of system-clock cycles, always rounded up. The serial clock's high and low phases, the gap from the last clock edge to the latch, and the latch width each have their own count. After a word is accepted, the block stays busy until a minimum update interval has passed, so the attenuator is never retuned faster than its allowed rate. A request that arrives while the block is busy is dropped and flagged. When the interval completes, the block raises a one-cycle completion pulse.

Top module: `atten_serial_master`

## Requirements
- R1: While reset is asserted and right after it is released, `busy`, `done`, `req_err`, `ser_clk`, `ser_le` and `ser_data` are all low.
- R2: A `req_valid` high at a clock edge while the block is idle is accepted; `busy` is high from the next cycle until the completion pulse.
- R3: Each accepted request produces exactly eight rising edges of `ser_clk`. The value of `ser_data` at the k-th rising edge is bit k-1 of the word, so bit 0 goes first. Bits 0 to 6 carry the code and bit 7 is always 0.
- R4: A `req_code` above 127 is sent as 127; codes 0 to 127 are sent unchanged.
- R5: Every high phase of `ser_clk`, and every low phase that ends in a rising edge, lasts at least HALF cycles. HALF is the larger of ceil(30 ns / Tclk) and half of ceil(Tclk-to-10 MHz period ratio), rounded up. This is 10 cycles at 200 MHz.
- R6: `ser_data` never changes in the cycle where `ser_clk` rises, nor while `ser_clk` stays high. It changes only together with a falling edge or while the clock is low.
- R7: `ser_le` is low while bits are being shifted. It rises only after all eight bits have been sent, at least HALF + ceil(10 ns / Tclk) cycles after the last `ser_clk` rising edge (12 cycles at 200 MHz).
- R8: `ser_le` stays high for exactly ceil(30 ns / Tclk) cycles (6 at 200 MHz) with `ser_clk` low, then returns low before any later word starts.
- R9: `busy` stays high for max(ceil(f_clk / MAX_UPDATE_HZ), 16·HALF + SETUP + WIDTH + 1) cycles after each acceptance.
- R10: `done` is high for exactly one cycle, in the first cycle where `busy` is low again.
- R11: A `req_valid` that arrives while `busy` is high raises `req_err` for one cycle on the next cycle. The request is discarded, and the word already in flight is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_code | input | 8 | Requested attenuation in quarter-dB steps |
| busy | output | 1 | A word is in flight or the update interval is running |
| done | output | 1 | One-cycle pulse when the update interval completes |
| req_err | output | 1 | One-cycle pulse: a request was rejected because the block was busy |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_clk | output | 1 | Serial shift clock to the attenuator |
| ser_le | output | 1 | Latch enable to the attenuator |

## Verification
On every cycle, the embedded properties check the following. Data is stable while the serial clock is high. Latch enable stays low during shifting and is never high together with the clock. The completion pulse lasts one cycle and falls in an idle cycle. A rejected request leaves the transfer running. Only the bench's scenarios can show that the word received on the pins equals the clamped code for every one of the 256 input values. They also measure the exact phase widths, the latch gap and width, and the total busy interval. Finally, they show that requests injected mid-shift and late in the hold-off period are flagged and leave the delivered word intact.

// File: rtl/atten_prog_pkg.sv
package atten_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT_LOW,
    ST_SHIFT_HIGH,
    ST_LE_SETUP,
    ST_LE_PULSE,
    ST_HOLDOFF
  } atten_state_e;

  // Minimum duration in ns -> whole clock cycles, rounded up, at least one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_hz);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(ns) * longint'(clk_hz);
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

  // Cycles per period of a rate limit, rounded up.
  function automatic int unsigned hz_to_cycles(input int unsigned rate_hz, input int unsigned clk_hz);
    longint unsigned cyc;
    cyc = (longint'(clk_hz) + longint'(rate_hz) - 64'd1) / longint'(rate_hz);
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/atten_tick_timer.sv
module atten_tick_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // a reload is never requested while the previous phase is still counting
  p_load_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load && !zero |-> $past(load) == 1'b0 && $past(cnt_q) != '0 ? 1'b0 : 1'b1)
    else $error("timer reloaded mid-phase");
endmodule

// File: rtl/atten_shift_reg.sv
module atten_shift_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] load_word,
  input  logic         shift,
  output logic         sdo,
  output logic         last_bit
);
  localparam int unsigned CW = $clog2(N + 1);

  logic [N-1:0]  sreg_q;
  logic [CW-1:0] sent_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q <= '0;
      sent_q <= '0;
    end else if (load) begin
      sreg_q <= load_word;
      sent_q <= '0;
    end else if (shift) begin
      sreg_q <= {1'b0, sreg_q[N-1:1]};
      sent_q <= sent_q + 1'b1;
    end
  end

  assign sdo      = sreg_q[0];
  assign last_bit = (sent_q == CW'(N - 1));

  p_shift_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> sent_q < CW'(N))
    else $error("more shifts than word bits");
endmodule

// File: rtl/atten_serial_master.sv
module atten_serial_master
  import atten_prog_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 200_000_000,
  parameter int unsigned MAX_SCLK_HZ   = 10_000_000,
  parameter int unsigned MIN_PHASE_NS  = 30,
  parameter int unsigned LE_SETUP_NS   = 10,
  parameter int unsigned LE_WIDTH_NS   = 30,
  parameter int unsigned MAX_UPDATE_HZ = 25_000,
  parameter int unsigned CODE_W        = 8,
  parameter int unsigned DATA_BITS     = 7,
  parameter int unsigned WORD_BITS     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  output logic              busy,
  output logic              done,
  output logic              req_err,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_le
);
  localparam int unsigned PERIOD_CYC = hz_to_cycles(MAX_SCLK_HZ, CLK_HZ);
  localparam int unsigned HALF_CYC   = max_u(ns_to_cycles(MIN_PHASE_NS, CLK_HZ), (PERIOD_CYC + 1) / 2);
  localparam int unsigned SETUP_CYC  = ns_to_cycles(LE_SETUP_NS, CLK_HZ);
  localparam int unsigned PW_CYC     = ns_to_cycles(LE_WIDTH_NS, CLK_HZ);
  localparam int unsigned UPDATE_CYC = hz_to_cycles(MAX_UPDATE_HZ, CLK_HZ);
  localparam int unsigned TMR_MAX    = max_u(HALF_CYC, max_u(SETUP_CYC, PW_CYC));
  localparam int unsigned TMR_W      = $clog2(TMR_MAX + 1);
  localparam int unsigned IVL_W      = $clog2(UPDATE_CYC + 1);
  localparam int unsigned MAX_CODE   = (1 << DATA_BITS) - 1;

  function automatic logic [WORD_BITS-1:0] frame_code(input logic [CODE_W-1:0] code);
    logic [WORD_BITS-1:0] w;
    w = '0;
    if (int'(code) > int'(MAX_CODE)) w[DATA_BITS-1:0] = DATA_BITS'(MAX_CODE);
    else                             w[DATA_BITS-1:0] = code[DATA_BITS-1:0];
    return w;
  endfunction

  atten_state_e state_q, state_d;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_last, sh_sdo;
  logic [IVL_W-1:0] ivl_q;

  // named internal events
  logic accept_ev, bit_done_ev, word_done_ev, holdoff_end_ev;

  assign busy           = (state_q != ST_IDLE);
  assign accept_ev      = (state_q == ST_IDLE) && req_valid;
  assign bit_done_ev    = (state_q == ST_SHIFT_HIGH) && tmr_zero;
  assign word_done_ev   = bit_done_ev && sh_last;
  assign holdoff_end_ev = (state_q == ST_HOLDOFF) && (ivl_q >= IVL_W'(UPDATE_CYC - 1));

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    case (state_q)
      ST_IDLE: if (accept_ev) begin
        state_d  = ST_SHIFT_LOW;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(HALF_CYC - 1);
        sh_load  = 1'b1;
      end
      ST_SHIFT_LOW: if (tmr_zero) begin
        state_d  = ST_SHIFT_HIGH;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(HALF_CYC - 1);
      end
      ST_SHIFT_HIGH: if (bit_done_ev) begin
        sh_shift = 1'b1;
        tmr_load = 1'b1;
        if (sh_last) begin
          state_d = ST_LE_SETUP;
          tmr_val = TMR_W'(SETUP_CYC - 1);
        end else begin
          state_d = ST_SHIFT_LOW;
          tmr_val = TMR_W'(HALF_CYC - 1);
        end
      end
      ST_LE_SETUP: if (tmr_zero) begin
        state_d  = ST_LE_PULSE;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(PW_CYC - 1);
      end
      ST_LE_PULSE: if (tmr_zero) state_d = ST_HOLDOFF;
      ST_HOLDOFF:  if (holdoff_end_ev) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ivl_q   <= '0;
      ser_clk <= 1'b0;
      ser_le  <= 1'b0;
      done    <= 1'b0;
      req_err <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_ev)                                  ivl_q <= '0;
      else if (busy && ivl_q != IVL_W'(UPDATE_CYC))   ivl_q <= ivl_q + 1'b1;
      ser_clk <= (state_d == ST_SHIFT_HIGH);
      ser_le  <= (state_d == ST_LE_PULSE);
      done    <= holdoff_end_ev;
      req_err <= req_valid && busy;
    end
  end

  atten_tick_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  atten_shift_reg #(.N(WORD_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_word(frame_code(req_code)),
    .shift(sh_shift), .sdo(sh_sdo), .last_bit(sh_last)
  );

  assign ser_data = sh_sdo;

  p_le_quiet_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT_LOW || state_q == ST_SHIFT_HIGH) |-> !ser_le)
    else $error("latch high during shifting");

  p_data_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk && $past(ser_clk) |-> $stable(ser_data))
    else $error("data moved while clock high");

  p_le_clk_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |-> !ser_clk)
    else $error("latch and clock high together");

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy)
    else $error("done while busy");

  p_reject_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid && !holdoff_end_ev |=> busy)
    else $error("rejected request disturbed transfer");
endmodule

// File: tb/sim_atten_serial_master.sv
module sim_atten_serial_master;
  localparam int CLK_HZ = 200_000_000;
  localparam int UPD_HZ = 1_000_000;
  localparam int TCLK_NS = 5;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  localparam int E_HALF  = (cdiv(30, TCLK_NS) > cdiv(cdiv(CLK_HZ, 10_000_000), 2)) ?
                           cdiv(30, TCLK_NS) : cdiv(cdiv(CLK_HZ, 10_000_000), 2);
  localparam int E_SETUP = cdiv(10, TCLK_NS);
  localparam int E_PW    = cdiv(30, TCLK_NS);
  localparam int E_XFER  = 16 * E_HALF + E_SETUP + E_PW + 1;
  localparam int E_BUSY  = (CLK_HZ / UPD_HZ > E_XFER) ? CLK_HZ / UPD_HZ : E_XFER;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_code = '0;
  logic busy, done, req_err, ser_data, ser_clk, ser_le;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  atten_serial_master #(.CLK_HZ(CLK_HZ), .MAX_UPDATE_HZ(UPD_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .busy(busy), .done(done), .req_err(req_err),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_word(input logic [7:0] code, input int poke_at, input logic [7:0] poke_code);
    int n, nbits, last_rise, le_hi, run, busy_cnt;
    int bad_r2, bad_r5, bad_r6, bad_r7, bad_r8, bad_r11, le_gap;
    logic [7:0] got;
    logic pc, pd, ple;
    bit done_seen;
    int exp_code;
    exp_code = (code > 8'd127) ? 127 : int'(code);
    n = 0; nbits = 0; last_rise = 0; le_hi = 0; run = 0; busy_cnt = 0;
    bad_r2 = 0; bad_r5 = 0; bad_r6 = 0; bad_r7 = 0; bad_r8 = 0; bad_r11 = 0; le_gap = -1;
    got = '0; done_seen = 0;
    @(negedge clk); req_valid = 1'b1; req_code = code;
    pc = ser_clk; pd = ser_data; ple = ser_le;
    @(negedge clk); req_valid = 1'b0;
    while (!done_seen && n < 2000) begin
      if (n == 0 && !busy) bad_r2++;
      if (busy) busy_cnt++;
      if (req_err != (poke_at > 0 && n == poke_at + 1)) bad_r11++;
      if (ser_clk != pc) begin
        if (pc || ser_clk) begin
          if (run < E_HALF) bad_r5++;
        end
        run = 1;
      end else run++;
      if (ser_clk && !pc) begin
        if (nbits < 8) got[nbits] = ser_data;
        if (ser_data != pd) bad_r6++;
        nbits++;
        last_rise = n;
      end
      if (ser_clk && pc && ser_data != pd) bad_r6++;
      if (ser_le && !ple) le_gap = n - last_rise;
      if (ser_le && nbits < 8) bad_r7++;
      if (ser_le && ser_clk) bad_r8++;
      if (ser_le) le_hi++;
      if (done) begin
        done_seen = 1;
        if (busy) bad_r2++;
      end
      if (poke_at > 0 && n == poke_at) begin
        req_valid = 1'b1; req_code = poke_code;
      end else req_valid = 1'b0;
      pc = ser_clk; pd = ser_data; ple = ser_le;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk(done_seen, "R10 done reached", int'(done_seen), 1);
    chk(done == 1'b0, "R10 done single cycle", int'(done), 0);
    chk(bad_r2 == 0, "R2 busy framing", bad_r2, 0);
    chk(nbits == 8, "R3 clock edges", nbits, 8);
    chk(int'(got[6:0]) == exp_code, "R3/R4 word bits", int'(got[6:0]), exp_code);
    chk(got[7] == 1'b0, "R3 top bit low", int'(got[7]), 0);
    chk(bad_r5 == 0, "R5 phase widths", bad_r5, 0);
    chk(bad_r6 == 0, "R6 data stability", bad_r6, 0);
    chk(bad_r7 == 0 && le_gap >= E_HALF + E_SETUP, "R7 latch gap", le_gap, E_HALF + E_SETUP);
    chk(bad_r8 == 0 && le_hi == E_PW, "R8 latch width", le_hi, E_PW);
    chk(busy_cnt == E_BUSY, "R9 busy interval", busy_cnt, E_BUSY);
    chk(bad_r11 == 0, "R11 reject flag", bad_r11, 0);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk({busy, done, req_err, ser_clk, ser_le, ser_data} == 6'b0, "R1 in reset",
        int'({busy, done, req_err, ser_clk, ser_le, ser_data}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, req_err, ser_clk, ser_le, ser_data} == 6'b0, "R1 after reset",
        int'({busy, done, req_err, ser_clk, ser_le, ser_data}), 0);
    // R3 R4: full code sweep, including clamped values
    for (int c = 0; c < 256; c++) run_word(8'(c), 0, 8'h00);
    // R11: request mid-shift and late in hold-off
    run_word(8'h2A, 50, 8'h55);
    run_word(8'd200, 190, 8'd3);
    run_word(8'd1, 3, 8'd126);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule